// File: doc/BRIEF.md
# Serial ADC Port Emulator

This block is a synthesizable device-side model of a single-channel serial ADC port. It is intended for testing host controllers. The host drives an active-low chip-select and a serial clock. The block answers with a 16-bit frame on a data output that can be switched off. A result word is loaded beforehand over a valid/ready stream input and held. The held word is captured as the sample when chip-select falls. The frame then shifts out four zeros, the result MSB first, and zero padding.

Both host pins pass through a synchronizer and edge detector in the system clock domain. Every pin change therefore takes effect three system cycles later. The block also models the rest of the sequence:
- the conversion-busy span and the acquisition point, both fixed to numbered SCLK edges;
- aborted frames;
- a power-down state entered by an early chip-select release;
- wake-up through a long dummy frame followed by a warm-up delay.

A flag reports whether the next frame will carry real data. A frame that starts while the flag is low carries zeros in place of the result.

Top module: `adc_serial_emu`

## Requirements
- R1: The third system clock edge after a chip-select fall (high to low) captures the held word. The same edge raises `sdo_oe` and `conv_busy`, clears `acq_active`, and shows a 0 on `sdo_bit`.
- R2: Each SCLK falling edge k (k = 1..15) in a frame advances the data bit. The frame word is {4 zero bits, result MSB first, zero padding to 16 bits}, and edge k shows bit 15-k of that word. `sdo_bit` reads 0 whenever `sdo_oe` is low.
- R3: The 16th SCLK falling edge of a frame drops `sdo_oe`.
- R4: `conv_busy` clears on SCLK falling edge RES_BITS+4. `acq_active` rises on the first SCLK rising edge after falling edge RES_BITS+3 and stays high until the next chip-select fall.
- R5: A chip-select rise during a frame drops `sdo_oe` and `conv_busy` immediately after it is detected.
- R6: A chip-select rise before the acquisition point, after 2 to 9 SCLK falling edges of a normal frame, sets `powered_down`. A rise outside that window does not.
- R7: In a frame that began powered down, the 11th SCLK falling edge clears `powered_down` and sets `next_valid`. A dummy frame released after 10 or fewer falling edges leaves the block powered down.
- R8: After a wake-up, the next frame carries real data only if its chip-select fall comes at least WAKE_CYCLES system cycles after the dummy frame's chip-select fall. Otherwise its result bits are zero.
- R9: `next_valid` clears when chip-select rises before the acquisition point in a normal frame. It is set at the acquisition point. A frame begun with `next_valid` low, or while powered down, carries zero result bits. `next_valid` resets low.
- R10: `res_ready` is the inverse of `conv_busy`. A word is stored on a clock edge where `res_valid` and `res_ready` are both high. While `res_ready` is low the held word stays unchanged, and the source holds its word until accepted.
- R11: After reset all outputs are low and `res_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_in | input | 1 | Host chip-select, active low, asynchronous |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| res_data | input | RES_BITS | Result word to load |
| res_valid | input | 1 | Result word offered |
| res_ready | output | 1 | Result word can be accepted |
| sdo_bit | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Serial data drive enable |
| conv_busy | output | 1 | Conversion in progress |
| acq_active | output | 1 | Acquisition point reached |
| powered_down | output | 1 | Power-down state |
| next_valid | output | 1 | Next frame will carry real data |

## Verification
The assertions assume that chip-select and SCLK change slowly compared with the system clock. They also assume that a chip-select edge and an SCLK edge never reach the edge detector in the same cycle. Under those conditions every detected pulse matches exactly one host edge. The stimulus meets this by holding each pin level for at least four system cycles. It also waits six cycles between a chip-select fall and the first SCLK fall, and four cycles after the last SCLK rise before releasing chip-select. All pin changes happen on the falling edge of the system clock.

// File: rtl/aem_pkg.sv
package aem_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_ZEROS = 4;
  localparam int CNT_W      = 5;
  localparam int PD_FIRST   = 2;
  localparam int PD_LAST    = 9;
  localparam int WAKE_FALL  = 10;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/aem_sync_edge.sv
module aem_sync_edge #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  output aem_pkg::edge_ev_t  ev
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= {STAGES{IDLE_VAL}};
      last_q <= IDLE_VAL;
    end else begin
      chain  <= {chain[STAGES-2:0], pin};
      last_q <= chain[STAGES-1];
    end
  end

  assign ev.rise = chain[STAGES-1] & ~last_q;
  assign ev.fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/aem_frame_shifter.sv
module aem_frame_shifter
  import aem_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  edge_ev_t              cs_ev,
  input  edge_ev_t              sck_ev,
  input  logic [FRAME_BITS-1:0] load_word,
  output logic                  in_frame,
  output logic [CNT_W-1:0]      fall_cnt,
  output logic                  sdo_bit,
  output logic                  sdo_oe,
  output logic                  conv_busy,
  output logic                  acq_active
);
  localparam int CONV_END = RES_BITS + LEAD_ZEROS;
  localparam logic [CNT_W-1:0] LAST_BEFORE_END = CNT_W'(CONV_END - 1);
  localparam logic [CNT_W-1:0] LAST_BIT        = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX         = {CNT_W{1'b1}};

  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      fall_cnt   <= '0;
      shreg      <= '0;
      sdo_oe     <= 1'b0;
      conv_busy  <= 1'b0;
      acq_active <= 1'b0;
    end else if (cs_ev.rise) begin
      in_frame  <= 1'b0;
      sdo_oe    <= 1'b0;
      conv_busy <= 1'b0;
      shreg     <= '0;
    end else if (cs_ev.fall) begin
      in_frame   <= 1'b1;
      fall_cnt   <= '0;
      shreg      <= load_word;
      sdo_oe     <= 1'b1;
      conv_busy  <= 1'b1;
      acq_active <= 1'b0;
    end else if (in_frame) begin
      if (sck_ev.fall) begin
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        if (fall_cnt != CNT_MAX) fall_cnt <= fall_cnt + 1'b1;
        if (fall_cnt == LAST_BIT) sdo_oe <= 1'b0;
        if (fall_cnt == LAST_BEFORE_END) conv_busy <= 1'b0;
      end
      if (sck_ev.rise && fall_cnt >= LAST_BEFORE_END) acq_active <= 1'b1;
    end
  end

  assign sdo_bit = sdo_oe & shreg[FRAME_BITS-1];
endmodule

// File: rtl/aem_power_ctrl.sv
module aem_power_ctrl
  import aem_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int WAKE_CYCLES = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edge_ev_t         cs_ev,
  input  edge_ev_t         sck_ev,
  input  logic             in_frame,
  input  logic [CNT_W-1:0] fall_cnt,
  input  logic             acq_active,
  output logic             powered_down,
  output logic             next_valid,
  output logic             frame_ok
);
  localparam int WARM_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(WAKE_CYCLES);
  localparam logic [CNT_W-1:0] ACQ_CNT = CNT_W'(RES_BITS + LEAD_ZEROS - 1);

  logic              frame_pd;
  logic              waking;
  logic [WARM_W-1:0] warm;
  logic              acq_in_frame;

  assign acq_in_frame = in_frame & acq_active;
  assign frame_ok = next_valid & ~powered_down & ~(waking & (warm < WARM_DONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powered_down <= 1'b0;
      next_valid   <= 1'b0;
      frame_pd     <= 1'b0;
      waking       <= 1'b0;
      warm         <= '0;
    end else begin
      if (cs_ev.fall && powered_down) warm <= WARM_W'(1);
      else if (warm < WARM_DONE) warm <= warm + 1'b1;

      if (cs_ev.rise) begin
        if (in_frame && !frame_pd && !acq_in_frame) begin
          next_valid <= 1'b0;
          if (fall_cnt >= CNT_W'(PD_FIRST) && fall_cnt <= CNT_W'(PD_LAST))
            powered_down <= 1'b1;
        end
      end else if (cs_ev.fall) begin
        frame_pd <= powered_down;
        waking   <= 1'b0;
      end else if (in_frame) begin
        if (sck_ev.fall && frame_pd && powered_down && fall_cnt == CNT_W'(WAKE_FALL)) begin
          powered_down <= 1'b0;
          next_valid   <= 1'b1;
          waking       <= 1'b1;
        end
        if (sck_ev.rise && !powered_down && !acq_active && fall_cnt >= ACQ_CNT)
          next_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import aem_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int WAKE_CYCLES = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_in,
  input  logic                sclk_in,
  input  logic [RES_BITS-1:0] res_data,
  input  logic                res_valid,
  output logic                res_ready,
  output logic                sdo_bit,
  output logic                sdo_oe,
  output logic                conv_busy,
  output logic                acq_active,
  output logic                powered_down,
  output logic                next_valid
);
  localparam int PAD_BITS = FRAME_BITS - LEAD_ZEROS - RES_BITS;

  edge_ev_t              cs_ev, sck_ev;
  logic                  in_frame, frame_ok;
  logic [CNT_W-1:0]      fall_cnt;
  logic [RES_BITS-1:0]   held_q;
  logic [FRAME_BITS-1:0] load_word;

  aem_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) cs_sync_i (
    .clk(clk), .rst_n(rst_n), .pin(cs_n_in), .ev(cs_ev));
  aem_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b0)) sck_sync_i (
    .clk(clk), .rst_n(rst_n), .pin(sclk_in), .ev(sck_ev));

  assign res_ready = ~conv_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else if (res_valid && res_ready) held_q <= res_data;
  end

  assign load_word = frame_ok ? (FRAME_BITS'(held_q) << PAD_BITS) : '0;

  aem_frame_shifter #(.RES_BITS(RES_BITS)) shifter_i (
    .clk(clk), .rst_n(rst_n), .cs_ev(cs_ev), .sck_ev(sck_ev),
    .load_word(load_word), .in_frame(in_frame), .fall_cnt(fall_cnt),
    .sdo_bit(sdo_bit), .sdo_oe(sdo_oe), .conv_busy(conv_busy),
    .acq_active(acq_active));

  aem_power_ctrl #(.RES_BITS(RES_BITS), .WAKE_CYCLES(WAKE_CYCLES)) power_i (
    .clk(clk), .rst_n(rst_n), .cs_ev(cs_ev), .sck_ev(sck_ev),
    .in_frame(in_frame), .fall_cnt(fall_cnt), .acq_active(acq_active),
    .powered_down(powered_down), .next_valid(next_valid), .frame_ok(frame_ok));
endmodule

// File: rtl/aem_checker.sv
module aem_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic in_frame,
  input logic sdo_bit,
  input logic sdo_oe,
  input logic conv_busy,
  input logic acq_active,
  input logic powered_down,
  input logic next_valid
);
  a_r1_oe_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $rose(conv_busy));
  a_r2_bit_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo_bit);
  a_r3_oe_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> in_frame);
  a_r5_abort_drops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!sdo_oe && !conv_busy));
  a_r6_pd_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> !next_valid);
  a_r6_pd_no_acq: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |-> !acq_active);
endmodule

bind adc_serial_emu aem_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_ev.rise), .in_frame(in_frame),
  .sdo_bit(sdo_bit), .sdo_oe(sdo_oe), .conv_busy(conv_busy),
  .acq_active(acq_active), .powered_down(powered_down), .next_valid(next_valid));

// File: tb/adc_serial_emu_tb.sv
module adc_serial_emu_tb_top;
  localparam int RES  = 10;
  localparam int WAKE = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1;
  logic [RES-1:0] res_data = '0;
  logic res_valid = 1'b0;
  logic res_ready, sdo_bit, sdo_oe, conv_busy, acq_active, powered_down, next_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_emu #(.RES_BITS(RES), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready),
    .sdo_bit(sdo_bit), .sdo_oe(sdo_oe), .conv_busy(conv_busy),
    .acq_active(acq_active), .powered_down(powered_down), .next_valid(next_valid));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int  m_cyc = 0, m_n = 0, m_tdum = 0;
  int  m_word = 0, m_hold = 0;
  bit  m_fr, m_oe, m_bz, m_aq, m_pd, m_nv, m_fpd, m_wk;
  bit  cs1, cs2, csp, sk1, sk2, skp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fr = 0; m_oe = 0; m_bz = 0; m_aq = 0; m_pd = 0; m_nv = 0; m_fpd = 0; m_wk = 0;
      m_hold = 0; m_n = 0; m_word = 0;
      cs1 = 1; cs2 = 1; csp = 1; sk1 = 0; sk2 = 0; skp = 0;
    end else begin
      bit cf, cr, sf, sr, ok, old_bz;
      cf = csp && !cs2; cr = !csp && cs2;
      sf = skp && !sk2; sr = !skp && sk2;
      old_bz = m_bz;
      if (cr) begin
        if (m_fr && !m_fpd && !m_aq) begin
          m_nv = 0;
          if (m_n >= 2 && m_n <= 9) m_pd = 1;
        end
        m_fr = 0; m_oe = 0; m_bz = 0;
      end else if (cf) begin
        ok = m_nv && !m_pd && !(m_wk && (m_cyc - m_tdum) < WAKE);
        if (m_pd) m_tdum = m_cyc;
        m_fpd = m_pd; m_wk = 0;
        m_fr = 1; m_n = 0; m_oe = 1; m_bz = 1; m_aq = 0;
        m_word = ok ? (m_hold << (16 - 4 - RES)) : 0;
      end else if (m_fr) begin
        if (sf) begin
          if (m_fpd && m_pd && m_n == 10) begin m_pd = 0; m_nv = 1; m_wk = 1; end
          m_n++;
          if (m_n == 16) m_oe = 0;
          if (m_n == RES + 4) m_bz = 0;
        end
        if (sr && m_n >= RES + 3 && !m_aq) begin
          m_aq = 1;
          if (!m_pd) m_nv = 1;
        end
      end
      if (res_valid && !old_bz) m_hold = int'(res_data);
      skp = sk2; sk2 = sk1; sk1 = sclk;
      csp = cs2; cs2 = cs1; cs1 = cs_n;
    end
    m_cyc++;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1/R3/R5 sdo_oe", sdo_oe, m_oe);
      chk("R2 sdo_bit", sdo_bit, m_oe ? ((m_word >> (15 - m_n)) & 1) : 0);
      chk("R4 conv_busy", conv_busy, m_bz);
      chk("R4 acq_active", acq_active, m_aq);
      chk("R6/R7 powered_down", powered_down, m_pd);
      chk("R8/R9 next_valid", next_valid, m_nv);
      chk("R10 res_ready", res_ready, !m_bz);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int d);
    res_data = RES'(d); res_valid = 1'b1;
    while (!res_ready) @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic frame(input int nf, input int quiet);
    cs_n = 1'b0;
    wait_n(6);
    for (int i = 0; i < nf; i++) begin
      sclk = 1'b0; wait_n(4);
      sclk = 1'b1; wait_n(4);
    end
    cs_n = 1'b1;
    wait_n(quiet);
  endtask

  initial begin
    wait_n(4);
    chk("R11 reset sdo_oe", sdo_oe, 0);
    chk("R11 reset powered_down", powered_down, 0);
    chk("R11 reset next_valid", next_valid, 0);
    chk("R11 reset res_ready", res_ready, 1);
    rst_n = 1'b1;
    wait_n(6);
    load(10'h2A5);
    frame(16, 8);              // zeros: no acquisition yet (R9)
    chk("R9 valid after full frame", next_valid, 1);
    frame(16, 8);              // real data 0x2A5 (R2)
    load(10'h3FF); frame(16, 8);
    load(10'h001); frame(14, 8);
    load(10'h155); frame(12, 8); // released before acquisition (R9)
    chk("R9 early release clears", next_valid, 0);
    chk("R6 12 falls no power-down", powered_down, 0);
    frame(16, 8);
    frame(1, 8);               // outside window: no power-down (R6)
    chk("R6 1 fall no power-down", powered_down, 0);
    frame(16, 8);
    frame(10, 8);
    chk("R6 10 falls no power-down", powered_down, 0);
    frame(16, 8);
    frame(5, 8);
    chk("R6 5 falls power-down", powered_down, 1);
    frame(8, 8);               // short dummy (R7)
    chk("R7 short dummy stays down", powered_down, 1);
    frame(11, 6);              // wake, then start too early (R8)
    chk("R7 woke", powered_down, 0);
    frame(16, 8);              // zeros expected (R8)
    load(10'h2C3); frame(16, 8);
    frame(2, 8);
    chk("R6 2 falls power-down", powered_down, 1);
    frame(11, 200);            // wake, respect delay (R8)
    frame(16, 8);              // real data expected (R8)
    load(10'h0F0);
    frame(9, 8);
    chk("R6 9 falls power-down", powered_down, 1);
    frame(16, 8);              // full dummy wakes (R7)
    frame(16, 8);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule